// File: doc/BRIEF.md
# Asynchronous static-memory bridge

The block connects a synchronous host to an asynchronous 16-bit static memory with 18 address bits. The memory has separate low-active enables for its lower and upper byte. The host raises a one-cycle request with an address, a write flag, a two-bit lane mask and write data. The bridge then runs one complete memory cycle on the pins. When the cycle ends, it pulses a one-cycle ready, and for a read it returns the captured word. While the bridge is busy it ignores requests.

Every memory time limit is a nanosecond parameter. Each limit becomes a count of clock cycles: the ceiling of the nanosecond value divided by the clock period, with a floor of one cycle. The bridge then holds each pin phase for that many cycles. All memory pins are registered. The data bus is split into an output word, an input word and a drive-enable, so the pad ring can build the bidirectional pin outside the block. After reset, the bridge refuses all accesses until a parameterised power-up wait has elapsed.

The default values are a 5 ns clock, 45 ns cycles, a 35 ns write pulse and address-to-end time, 25 ns data setup, 22 ns enable-to-data and 18 ns bus release. These give the following counts:
- power-up wait N_PU = 40000
- read phase N_RD = 9
- release N_HZ = 4
- write pulse N_WP = 9
- write cycle N_WC = 9

Top module: `sram_bridge`

## Requirements
- R1: After reset is released, chip enable stays high and no request is taken for N_PU = ceil(PWRUP_NS/CLK_NS) cycles. A request held high from reset first drives chip enable low after clock edge N_PU+1.
- R2: While reset is low, chip, write, output and both byte enables are high, the drive-enable is low and ready is low.
- R3: A read holds chip enable and output enable low and write enable high for exactly N_RD cycles. N_RD is the largest of the cycle counts for read cycle, address-to-data, output-enable-to-data and byte-enable-to-data. The request address is on the address pins, and each byte enable is the inverse of its mask bit (bit 0 is the lower byte, data bits 7:0; bit 1 is the upper byte, bits 15:8).
- R4: Read data is captured on the last cycle of the read phase. A lane whose mask bit is 0 returns 0. Ready is high in the cycle after the phase, with a latency of N_RD+1 from the accepting edge.
- R5: A write holds write enable low, with output enable high, for exactly N_WP cycles. N_WP is the largest of the pulse count, the address-to-end count and N_HZ plus the data-setup count. Each byte enable is the inverse of its mask bit.
- R6: The drive-enable is high only while write enable is low and output enable is high. It rises in the (N_HZ+1)th cycle of the write pulse, where N_HZ is the larger of the two release counts, and it carries the write data until write enable rises.
- R7: During an access the address is stable while chip enable is low. A write keeps chip enable low for max(N_WC, N_WP) cycles, after which ready follows.
- R8: Ready is high for exactly one cycle per access. A request raised while an access is in progress starts no further access.
- R9: Between two accesses there is at least one cycle with all controls high and the bus released. A request held high through ready starts the next access after exactly one such cycle.
- R10: A write with mask 00 runs its full cycle with both byte enables high, and no memory lane changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Word address |
| be_i | input | 2 | Lane mask, bit 0 lower byte |
| wdata_i | input | 16 | Write data |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Captured read data |
| sram_addr_o | output | 18 | Memory address |
| sram_ce_n_o | output | 1 | Chip enable, active low |
| sram_we_n_o | output | 1 | Write enable, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_be_n_o | output | 2 | Byte enables, active low, bit 0 lower byte |
| sram_dq_o | output | 16 | Data driven to memory |
| sram_dq_oe_o | output | 1 | Data bus drive enable |
| sram_dq_i | input | 16 | Data returned by memory |

## Verification
The bench sweeps every lane mask, for writes and reads, over edge and checkerboard addresses, and compares each word with a reference built from the masks. A bridge that ignored a lane would corrupt the other byte or return stale bits where zeros are due. Pulse lengths, the point where drive-enable rises, and access latency are measured at the pins against counts derived from the nanosecond limits. An off-by-one counter shows up as a pulse one cycle short, or as drive starting before the memory has released the bus. The bench also covers the power-up lockout, a request pulsed while busy (which must not become a phantom access), back-to-back requests (which must keep a one-cycle gap) and an empty-mask write (which must leave memory untouched).

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_WREC
  } seq_st_e;

  // ceil(ns / clk_ns), never below one cycle
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_pwrup_gate.sv
module sram_pwrup_gate #(
  parameter int unsigned WAIT_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int unsigned CW = $clog2(WAIT_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(WAIT_CYC - 1)) done_q <= 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o
);
  logic [W-1:0] cnt_q;

  assign cnt_nxt_o = clr_i ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sram_lane_mux.sv
module sram_lane_mux #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANES-1:0]        en_i,
  input  logic [LANES*LANE_W-1:0] d_i,
  output logic [LANES*LANE_W-1:0] d_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign d_o[g*LANE_W +: LANE_W] = en_i[g] ? d_i[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned LANES     = 2,
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned CLK_NS    = 5,
  parameter int unsigned PWRUP_NS  = 200000,
  parameter int unsigned T_RC_NS   = 45,
  parameter int unsigned T_AA_NS   = 45,
  parameter int unsigned T_DOE_NS  = 22,
  parameter int unsigned T_DBE_NS  = 22,
  parameter int unsigned T_WC_NS   = 45,
  parameter int unsigned T_PWE_NS  = 35,
  parameter int unsigned T_AW_NS   = 35,
  parameter int unsigned T_SD_NS   = 25,
  parameter int unsigned T_HZOE_NS = 18,
  parameter int unsigned T_HZWE_NS = 18
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [LANES-1:0]         be_i,
  input  logic [LANES*LANE_W-1:0]  wdata_i,
  output logic                     ready_o,
  output logic [LANES*LANE_W-1:0]  rdata_o,
  output logic [ADDR_W-1:0]        sram_addr_o,
  output logic                     sram_ce_n_o,
  output logic                     sram_we_n_o,
  output logic                     sram_oe_n_o,
  output logic [LANES-1:0]         sram_be_n_o,
  output logic [LANES*LANE_W-1:0]  sram_dq_o,
  output logic                     sram_dq_oe_o,
  input  logic [LANES*LANE_W-1:0]  sram_dq_i
);
  localparam int unsigned DATA_W = LANES * LANE_W;
  localparam int unsigned N_PU   = ns2cyc(PWRUP_NS, CLK_NS);
  localparam int unsigned N_RD   = imax(imax(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS)),
                                        imax(ns2cyc(T_DOE_NS, CLK_NS), ns2cyc(T_DBE_NS, CLK_NS)));
  localparam int unsigned N_HZ   = imax(ns2cyc(T_HZOE_NS, CLK_NS), ns2cyc(T_HZWE_NS, CLK_NS));
  localparam int unsigned N_WP   = imax(imax(ns2cyc(T_PWE_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                        N_HZ + ns2cyc(T_SD_NS, CLK_NS));
  localparam int unsigned N_WC   = ns2cyc(T_WC_NS, CLK_NS);
  localparam int unsigned N_WREC = (N_WC > N_WP) ? (N_WC - N_WP) : 0;
  localparam int unsigned CNT_W  = $clog2(imax(imax(N_RD, N_WP), N_WREC) + 1);
  localparam logic [CNT_W-1:0] LAST_RD   = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] LAST_WP   = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] LAST_WREC = CNT_W'(imax(N_WREC, 1) - 1);
  localparam logic [CNT_W-1:0] DRV_FROM  = CNT_W'(N_HZ);

  seq_st_e            st_q, st_d;
  logic               pu_done;
  logic               cnt_clr;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               take, fin;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [LANES-1:0]   mask_q, mask_d;
  logic [DATA_W-1:0]  wdata_q, wdata_d;
  logic [DATA_W-1:0]  rd_lanes;
  logic [DATA_W-1:0]  rdata_q;
  logic               ready_q;

  logic               ce_n_q, we_n_q, oe_n_q, dq_oe_q;
  logic [LANES-1:0]   be_n_q;
  logic [ADDR_W-1:0]  pin_addr_q;
  logic [DATA_W-1:0]  pin_dq_q;

  sram_pwrup_gate #(.WAIT_CYC(N_PU)) u_pwrup (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_o (pu_done)
  );

  sram_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cnt_clr),
    .cnt_o     (cnt_q),
    .cnt_nxt_o (cnt_d)
  );

  sram_lane_mux #(.LANES(LANES), .LANE_W(LANE_W)) u_rmux (
    .en_i (mask_q),
    .d_i  (sram_dq_i),
    .d_o  (rd_lanes)
  );

  always_comb begin
    st_d = st_q;
    take = 1'b0;
    fin  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (pu_done && req_i) begin
        st_d = we_i ? ST_WR : ST_RD;
        take = 1'b1;
      end
      ST_RD: if (cnt_q == LAST_RD) begin
        st_d = ST_IDLE;
        fin  = 1'b1;
      end
      ST_WR: if (cnt_q == LAST_WP) begin
        if (N_WREC == 0) begin
          st_d = ST_IDLE;
          fin  = 1'b1;
        end else begin
          st_d = ST_WREC;
        end
      end
      ST_WREC: if (cnt_q == LAST_WREC) begin
        st_d = ST_IDLE;
        fin  = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign cnt_clr = (st_d != st_q) || (st_q == ST_IDLE);
  assign addr_d  = take ? addr_i  : addr_q;
  assign mask_d  = take ? be_i    : mask_q;
  assign wdata_d = take ? wdata_i : wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      mask_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ready_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      mask_q  <= mask_d;
      wdata_q <= wdata_d;
      ready_q <= fin;
      if (st_q == ST_RD && cnt_q == LAST_RD) rdata_q <= rd_lanes;
    end
  end

  // pins registered from next state so no decode glitch reaches the memory
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_q     <= 1'b1;
      we_n_q     <= 1'b1;
      oe_n_q     <= 1'b1;
      be_n_q     <= '1;
      dq_oe_q    <= 1'b0;
      pin_addr_q <= '0;
      pin_dq_q   <= '0;
    end else begin
      ce_n_q     <= (st_d == ST_IDLE);
      we_n_q     <= (st_d != ST_WR);
      oe_n_q     <= (st_d != ST_RD);
      be_n_q     <= (st_d == ST_IDLE) ? '1 : ~mask_d;
      dq_oe_q    <= (st_d == ST_WR) && (cnt_d >= DRV_FROM);
      pin_addr_q <= addr_d;
      pin_dq_q   <= wdata_d;
    end
  end

  assign ready_o      = ready_q;
  assign rdata_o      = rdata_q;
  assign sram_addr_o  = pin_addr_q;
  assign sram_ce_n_o  = ce_n_q;
  assign sram_we_n_o  = we_n_q;
  assign sram_oe_n_o  = oe_n_q;
  assign sram_be_n_o  = be_n_q;
  assign sram_dq_o    = pin_dq_q;
  assign sram_dq_oe_o = dq_oe_q;
endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned N_PU   = 4,
  parameter int unsigned N_WP   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_ce_n_o,
  input logic              sram_we_n_o,
  input logic              sram_oe_n_o,
  input logic              sram_dq_oe_o
);
  int unsigned since_rst;
  int unsigned we_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst <= 0;
      we_run    <= 0;
    end else begin
      if (since_rst <= N_PU) since_rst <= since_rst + 1;
      if (sram_we_n_o)            we_run <= 0;
      else if (we_run <= N_WP)    we_run <= we_run + 1;
    end
  end

  p_pwrup_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst <= N_PU) |-> sram_ce_n_o);

  p_rd_wr_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sram_oe_n_o && !sram_we_n_o));

  p_we_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_we_n_o && we_run != 0) |-> (we_run == N_WP));

  p_drive_win_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> (!sram_we_n_o && sram_oe_n_o));

  p_addr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_n_o && $past(!sram_ce_n_o)) |-> $stable(sram_addr_o));

  p_ready_one_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  p_ready_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_ce_n_o && sram_we_n_o && sram_oe_n_o && !sram_dq_oe_o));
endmodule

bind sram_bridge sram_bridge_chk #(
  .ADDR_W (ADDR_W),
  .N_PU   (N_PU),
  .N_WP   (N_WP)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ready_o      (ready_o),
  .sram_addr_o  (sram_addr_o),
  .sram_ce_n_o  (sram_ce_n_o),
  .sram_we_n_o  (sram_we_n_o),
  .sram_oe_n_o  (sram_oe_n_o),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sim_sram_bridge.sv
`timescale 1ns/1ps
module sim_sram_bridge;
  function automatic int cyc(input int ns);
    int c;
    c = (ns + 4) / 5;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_PU = cyc(200000);
  localparam int E_RD = mx(mx(cyc(45), cyc(45)), cyc(22));
  localparam int E_HZ = cyc(18);
  localparam int E_WP = mx(cyc(35), E_HZ + cyc(25));
  localparam int E_WC = mx(cyc(45), E_WP);

  logic        clk, rst_n;
  logic        req, we;
  logic [17:0] addr;
  logic [1:0]  be;
  logic [15:0] wdata;
  logic        ready;
  logic [15:0] rdata;
  logic [17:0] m_addr;
  logic        ce_n, we_n, oe_n, dq_oe;
  logic [1:0]  be_n;
  logic [15:0] dq_o, dq_i;

  sram_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .be_i(be),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata), .sram_addr_o(m_addr),
    .sram_ce_n_o(ce_n), .sram_we_n_o(we_n), .sram_oe_n_o(oe_n), .sram_be_n_o(be_n),
    .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [15:0] mem_m [int];
  logic [15:0] ref_m [int];

  function automatic logic [15:0] peek(input int a);
    return mem_m.exists(a) ? mem_m[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] peek_ref(input int a);
    return ref_m.exists(a) ? ref_m[a] : 16'h0000;
  endfunction

  // memory model: undriven lanes read as A5
  always @* begin
    dq_i = 16'hA5A5;
    if (!ce_n && !oe_n && we_n) begin
      if (!be_n[0]) dq_i[7:0]  = peek(int'(m_addr))[7:0];
      if (!be_n[1]) dq_i[15:8] = peek(int'(m_addr))[15:8];
    end
  end

  int we_run = 0, oe_run = 0, ce_run = 0, ce_hi_run = 0;
  int last_we_len = 0, last_oe_len = 0, last_ce_len = 0, last_gap = 0, drv_ofs = 0;
  int viol_drv = 0, viol_addr = 0;
  logic [1:0]  be_at_we, be_at_oe;
  logic [17:0] addr_at_ce, prev_addr;
  logic [15:0] last_dq;
  logic        prev_ce_n = 1'b1, prev_dq_oe = 1'b0;

  always @(negedge clk) begin
    if (!ce_n && !we_n && dq_oe) begin
      logic [15:0] w;
      w = peek(int'(m_addr));
      if (!be_n[0]) w[7:0]  = dq_o[7:0];
      if (!be_n[1]) w[15:8] = dq_o[15:8];
      mem_m[int'(m_addr)] = w;
    end
    if (!we_n) begin we_run++; be_at_we = be_n; end
    else begin if (we_run != 0) last_we_len = we_run; we_run = 0; end
    if (!oe_n) begin oe_run++; be_at_oe = be_n; end
    else begin if (oe_run != 0) last_oe_len = oe_run; oe_run = 0; end
    if (!ce_n) begin
      if (prev_ce_n) begin last_gap = ce_hi_run; addr_at_ce = m_addr; end
      else if (m_addr != prev_addr) viol_addr++;
      ce_run++; ce_hi_run = 0;
    end else begin
      if (ce_run != 0) last_ce_len = ce_run;
      ce_run = 0; ce_hi_run++;
    end
    if (dq_oe && !prev_dq_oe) drv_ofs = we_run;
    if (dq_oe) last_dq = dq_o;
    if (dq_oe && (we_n || !oe_n)) viol_drv++;
    prev_ce_n = ce_n; prev_dq_oe = dq_oe; prev_addr = m_addr;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [17:0] a, input logic [1:0] m,
                        input logic [15:0] d, output logic [15:0] r, output int lat);
    @(negedge clk);
    req = 1'b1; we = wr; addr = a; be = m; wdata = d;
    @(negedge clk);
    req = 1'b0; lat = 1;
    while (!ready && lat < 1000) begin @(negedge clk); lat++; end
    r = rdata;
    #1;
  endtask

  task automatic do_write(input logic [17:0] a, input logic [1:0] m, input logic [15:0] d);
    logic [15:0] r, e;
    int lat;
    access(1'b1, a, m, d, r, lat);
    chk(lat == E_WC + 1, "R7 write latency", lat, E_WC + 1);
    chk(last_ce_len == E_WC, "R7 write ce low", last_ce_len, E_WC);
    chk(last_we_len == E_WP, "R5 we pulse", last_we_len, E_WP);
    chk(be_at_we == ~m, "R5 be_n", be_at_we, ~m);
    chk(drv_ofs == E_HZ + 1, "R6 drive start", drv_ofs, E_HZ + 1);
    chk(last_dq == d, "R6 drive data", last_dq, d);
    chk(addr_at_ce == a, "R7 write addr", addr_at_ce, a);
    e = peek_ref(int'(a));
    if (m[0]) e[7:0]  = d[7:0];
    if (m[1]) e[15:8] = d[15:8];
    ref_m[int'(a)] = e;
  endtask

  task automatic do_read(input logic [17:0] a, input logic [1:0] m);
    logic [15:0] r, e;
    int lat;
    access(1'b0, a, m, 16'h0, r, lat);
    e = peek_ref(int'(a)) & {{8{m[1]}}, {8{m[0]}}};
    chk(lat == E_RD + 1, "R4 read latency", lat, E_RD + 1);
    chk(last_oe_len == E_RD, "R3 oe pulse", last_oe_len, E_RD);
    chk(be_at_oe == ~m, "R3 be_n", be_at_oe, ~m);
    chk(addr_at_ce == a, "R3 read addr", addr_at_ce, a);
    chk(r == e, "R4 read data", r, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [17:0] addrs [6];
    logic [15:0] r;
    int n, lat, ce_falls, rdy_seen;
    addrs[0] = 18'h00000; addrs[1] = 18'h3FFFF; addrs[2] = 18'h2AAAA;
    addrs[3] = 18'h15555; addrs[4] = 18'h00100; addrs[5] = 18'h20001;
    rst_n = 1'b0; req = 1'b1; we = 1'b0; addr = 18'h00000; be = 2'b11; wdata = 16'h0;
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && oe_n && be_n == 2'b11 && !dq_oe && !ready,
        "R2 reset state", {ce_n, we_n, oe_n, be_n, dq_oe, ready}, 7'b1111110);

    // R1: request held from reset release
    rst_n = 1'b1;
    n = 0; rdy_seen = 0;
    while (ce_n && n < E_PU + 20) begin
      @(negedge clk); n++;
      if (ready) rdy_seen++;
    end
    req = 1'b0;
    chk(n == E_PU + 1, "R1 power-up lockout", n, E_PU + 1);
    chk(rdy_seen == 0, "R1 no ready in lockout", rdy_seen, 0);
    while (!ready) @(negedge clk);
    #1;

    // sweep: every mask for writes, every mask for reads
    foreach (addrs[i]) begin
      for (int m = 1; m < 4; m++)
        do_write(addrs[i], 2'(m), 16'(addrs[i][15:0] ^ (16'h1357 * m)));
      for (int m = 0; m < 4; m++)
        do_read(addrs[i], 2'(m));
    end

    // R10: empty-mask write changes nothing
    foreach (addrs[i]) begin
      do_write(addrs[i], 2'b00, 16'hFFFF);
      chk(be_at_we == 2'b11, "R10 be_n idle on empty mask", be_at_we, 2'b11);
      chk(peek(int'(addrs[i])) == peek_ref(int'(addrs[i])), "R10 memory unchanged",
          peek(int'(addrs[i])), peek_ref(int'(addrs[i])));
      do_read(addrs[i], 2'b11);
    end

    // R8: request pulsed while busy is dropped
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 18'h00ABC; be = 2'b11; wdata = 16'hBEEF;
    @(negedge clk); req = 1'b0;
    repeat (3) @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 18'h00DEF;
    @(negedge clk); req = 1'b0;
    while (!ready) @(negedge clk);
    ref_m[18'h00ABC] = 16'hBEEF;
    @(negedge clk);
    chk(!ready, "R8 ready one cycle", ready, 0);
    ce_falls = 0; rdy_seen = 0;
    for (int k = 0; k < 12; k++) begin
      if (!ce_n) ce_falls++;
      if (ready) rdy_seen++;
      @(negedge clk);
    end
    chk(ce_falls == 0 && rdy_seen == 0, "R8 busy request ignored", ce_falls + rdy_seen, 0);

    // R9: request held through ready gives a one-cycle gap
    req = 1'b1; we = 1'b0; addr = 18'h00ABC; be = 2'b11;
    @(negedge clk);
    while (!ready) @(negedge clk);
    @(negedge clk);
    chk(!ce_n, "R9 next access started", ce_n, 0);
    req = 1'b0;
    while (!ready) @(negedge clk);
    r = rdata;
    #1;
    chk(last_gap == 1, "R9 idle gap", last_gap, 1);
    chk(r == 16'hBEEF, "R4 back-to-back read data", r, 16'hBEEF);

    do_read(18'h00ABC, 2'b01);
    chk(viol_drv == 0, "R6 drive outside write", viol_drv, 0);
    chk(viol_addr == 0, "R7 address moved under ce", viol_addr, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule